// File: doc/BRIEF.md
# Bit-Serial Phase-Accumulator Frequency Synthesizer

This block generates a square wave whose frequency is a fraction of its input clock. A phase accumulator and a frequency step word are held in two shift registers. Both are added one bit per clock through a single full adder, least significant bit first. A full update of the accumulator therefore takes one clock per bit of the word. The square wave is the accumulator's top bit, sampled once per finished word.

The step is an unsigned fraction with the binary point just above its top bit. It is captured from the input port while the synchronous reset is high and then circulates unchanged. The output frequency is the clock frequency times the step, divided by the word width and by two to the power of the word width. This holds for steps up to one half. A strobe marks each completed word. It lets downstream logic sample the wave, or count words, at the instants when the wave can change.

Top module: `serial_phase_synth`

## Requirements
- R1: While reset is high the step port is captured, the accumulator loads parameter ACC_INIT (default 0), strobe_o is 0 and wave_o equals bit W-1 of ACC_INIT.
- R2: strobe_o is high for exactly one clock in every W clocks. Its first pulse is in the W-th clock after reset is released.
- R3: After the k-th strobe, wave_o equals bit W-1 of (ACC_INIT + k*step) mod 2^W. wave_o does not change in any clock in which strobe_o is low.
- R4: The step port is ignored while reset is low. Changing it mid-run does not alter wave_o or strobe_o.
- R5: With W=32 and ACC_INIT=0, steps 32'h8000_0000, 32'h4000_0000, 32'h1000_0000 and 32'h0800_0000 give wave periods of exactly 64, 128, 512 and 1024 clocks.
- R6: With step 32'h3000_0000 the wave period is not a whole number on average. Each period between rising edges is either 160 or 192 clocks.
- R7: Addition is modulo 2^W. The carry out of the top bit is discarded and does not enter the next word's lowest bit. For example, step 32'hFFFF_FFFF makes the accumulator count down by one per word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; loads step and accumulator |
| step_i | input | W | Frequency step, a 0.W unsigned fraction, sampled only in reset |
| wave_o | output | 1 | Square wave, accumulator MSB after each word |
| strobe_o | output | 1 | One-clock pulse at each completed word |

## Verification
The first strobe, and the first update of the wave, are due on the W-th rising edge after the edge at which reset is first seen low. Each later strobe and wave update comes exactly W edges after the one before. The bench counts edges from reset release and samples on the falling edge after every rising edge. Every W-th sample checks the strobe, and checks the wave against a bench accumulator advanced by the step. Every other sample checks that the strobe is low and the wave unchanged. Wave periods are measured as the number of edges between rising transitions of the wave.

// File: rtl/sps_pkg.sv
package sps_pkg;
   localparam int unsigned SPS_DEFAULT_W = 32;

   function automatic int unsigned sps_idx_w(input int unsigned width);
      return (width < 2) ? 1 : $clog2(width);
   endfunction
endpackage

// File: rtl/sps_bit_counter.sv
module sps_bit_counter #(
   parameter int unsigned W = sps_pkg::SPS_DEFAULT_W,
   localparam int unsigned IW = sps_pkg::sps_idx_w(W)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   output logic [IW-1:0] idx_o,
   output logic          first_o,
   output logic          last_o
);
   localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         idx_q <= '0;
      else if (idx_q == LAST_IDX)
         idx_q <= '0;
      else
         idx_q <= idx_q + 1'b1;
   end

   assign idx_o   = idx_q;
   assign first_o = (idx_q == '0);
   assign last_o  = (idx_q == LAST_IDX);

   assert_cnt_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      last_o |=> (idx_o == '0));
endmodule

// File: rtl/sps_shift_reg.sv
module sps_shift_reg #(
   parameter int unsigned W       = sps_pkg::SPS_DEFAULT_W,
   parameter bit          IS_RING = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] load_i,
   input  logic         ser_i,
   output logic         lsb_o
);
   logic [W-1:0] word_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         word_q <= load_i;
      else
         word_q <= {ser_i, word_q[W-1:1]};
   end

   assign lsb_o = word_q[0];

   generate
      if (IS_RING) begin : g_ring_check
         assert_step_popcount_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            !$past(rst_i) |-> ($countones(word_q) == $countones($past(word_q))));
      end
   endgenerate
endmodule

// File: rtl/sps_serial_adder.sv
module sps_serial_adder (
   input  logic clk_i,
   input  logic rst_i,
   input  logic first_i,
   input  logic a_i,
   input  logic b_i,
   output logic sum_o
);
   logic carry_q;
   logic cin;

   assign cin   = first_i ? 1'b0 : carry_q;
   assign sum_o = a_i ^ b_i ^ cin;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         carry_q <= 1'b0;
      else
         carry_q <= (a_i & b_i) | (a_i & cin) | (b_i & cin);
   end

   // R7: a word whose operand bits are both zero at bit 0 must give sum 0 there
   assert_no_carry_leak_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (first_i && !a_i && !b_i) |-> !sum_o);
endmodule

// File: rtl/serial_phase_synth.sv
module serial_phase_synth #(
   parameter int unsigned W        = sps_pkg::SPS_DEFAULT_W,
   parameter logic [W-1:0] ACC_INIT = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] step_i,
   output logic         wave_o,
   output logic         strobe_o
);
   localparam int unsigned IW = sps_pkg::sps_idx_w(W);

   generate
      if (W < 2) begin : g_bad_width
         $error("serial_phase_synth: W must be at least 2");
      end
   endgenerate

   logic [IW-1:0] bit_idx;
   logic          first_bit;
   logic          last_bit;
   logic          acc_lsb;
   logic          step_lsb;
   logic          sum_bit;

   sps_bit_counter #(.W(W)) u_cnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .idx_o   (bit_idx),
      .first_o (first_bit),
      .last_o  (last_bit)
   );

   sps_shift_reg #(.W(W), .IS_RING(1'b1)) u_step (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (step_i),
      .ser_i  (step_lsb),
      .lsb_o  (step_lsb)
   );

   sps_shift_reg #(.W(W), .IS_RING(1'b0)) u_acc (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (ACC_INIT),
      .ser_i  (sum_bit),
      .lsb_o  (acc_lsb)
   );

   sps_serial_adder u_add (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .first_i (first_bit),
      .a_i     (acc_lsb),
      .b_i     (step_lsb),
      .sum_o   (sum_bit)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         wave_o   <= ACC_INIT[W-1];
         strobe_o <= 1'b0;
      end else begin
         strobe_o <= last_bit;
         if (last_bit)
            wave_o <= sum_bit;
      end
   end

   assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> !strobe_o);

   assert_strobe_at_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |-> (bit_idx == '0));

   assert_wave_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!strobe_o && !$past(rst_i)) |-> $stable(wave_o));
endmodule

// File: tb/serial_phase_synth_tb.sv
`timescale 1ns/1ps
module serial_phase_synth_tb_top;
   localparam int unsigned W = 32;
   localparam logic [W-1:0] ACC_INIT = '0;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] step_word = '0;
   logic         wave;
   logic         strobe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cycles++;

   serial_phase_synth #(.W(W), .ACC_INIT(ACC_INIT)) dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .step_i   (step_word),
      .wave_o   (wave),
      .strobe_o (strobe)
   );

   function automatic logic [W-1:0] next_acc(input logic [W-1:0] acc, input logic [W-1:0] stp);
      return acc + stp;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // mode 0: no period check, 1: exact period per (R5), 2: 160 or 192 (R6)
   task automatic run_case(input logic [W-1:0] stp, input int words, input int mode,
                           input int per, input bit poke, input string req);
      logic [W-1:0] model;
      logic         prev_wave;
      int           last_rise;
      step_word = stp;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(strobe == 1'b0, "R1 strobe", W'(strobe), '0);
      chk(wave == ACC_INIT[W-1], "R1 wave", W'(wave), W'(ACC_INIT[W-1]));
      rst = 1'b0;
      model = ACC_INIT;
      prev_wave = wave;
      last_rise = -1;
      for (int n = 1; n <= words * int'(W); n++) begin
         @(posedge clk);
         @(negedge clk);
         if (poke && n == 40) step_word = ~stp ^ W'(n);
         if (n % int'(W) == 0) begin
            model = next_acc(model, stp);
            chk(strobe == 1'b1, "R2 strobe due", W'(strobe), W'(1));
            chk(wave == model[W-1], req, W'(wave), W'(model[W-1]));
         end else begin
            chk(strobe == 1'b0, "R2 strobe idle", W'(strobe), '0);
            chk(wave == prev_wave, "R3 hold", W'(wave), W'(prev_wave));
         end
         if (wave && !prev_wave) begin
            if (last_rise >= 0 && mode == 1)
               chk((n - last_rise) == per, "R5 period", W'(n - last_rise), W'(per));
            if (last_rise >= 0 && mode == 2)
               chk((n - last_rise) == 160 || (n - last_rise) == 192, "R6 period",
                   W'(n - last_rise), W'(160));
            last_rise = n;
         end
         prev_wave = wave;
      end
   endtask

   initial begin : watchdog
      while (cycles < 200000 && !done) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired at cycle %0d", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] r;
      r = W'($urandom(32'd1234));
      run_case(32'h8000_0000, 20, 1, 64,   1'b0, "R5 wave 1/2");
      run_case(32'h4000_0000, 20, 1, 128,  1'b0, "R5 wave 1/4");
      run_case(32'h1000_0000, 70, 1, 512,  1'b0, "R5 wave 1/16");
      run_case(32'h0800_0000, 100, 1, 1024, 1'b0, "R5 wave 1/32");
      run_case(32'h3000_0000, 80, 2, 0,    1'b0, "R6 wave");
      run_case(32'h1001_0000, 40, 0, 0,    1'b0, "R3 wave");
      run_case(32'hFFFF_FFFF, 40, 0, 0,    1'b0, "R7 wrap wave");
      run_case(32'h0000_0001, 8,  0, 0,    1'b0, "R7 carry wave");
      run_case(32'h0000_0000, 8,  0, 0,    1'b0, "R3 zero wave");
      run_case(32'h2468_ACE1, 40, 0, 0,    1'b1, "R4 ignored step wave");
      for (int k = 0; k < 6; k++) begin
         r = W'($urandom());
         run_case(r, 40, 0, 0, k[0], "R3 random wave");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule